// File: doc/BRIEF.md
# Single-Wire Activation Deglitch Sequencer

A shared output pin normally carries an analog level from a DAC. It can also be switched over to a bidirectional single-wire digital link. An analog comparator watches that pin for an out-of-band high voltage. This block takes the comparator's raw flag, passes it through a synchronizer, and decides whether a genuine activation request has arrived. A request counts only when two windows of the same length are met in turn. First the high voltage must be held. Then, after it ends, the pin must sit back at normal logic level. Only then does the block send a one-cycle interrupt to the local processor, which switches the pin over to the digital link.

Window length is counted in ticks from an internal prescaler that runs off the system clock. The prescale value is an input, so a bench or a slow clock domain can shorten or stretch the tick. A select input picks a short window of 1 tick or a long window of 10 ticks. With a 1 ms tick these give 1 ms and 10 ms. The block also drives the DAC-enable line. It turns the DAC off while the high voltage is present and turns it back on while the return to normal level is being checked. After the interrupt the block stays locked, with the DAC off, until software re-arms it.

Top module: `swire_act_seq`

## Requirements
- R1: In reset and right after it, `phase` is 0 (idle), `dac_en` is 1 and `act_irq` is 0.
- R2: One window W lasts N × (`tick_div` + 1) clock cycles. N is 1 when `long_sel` is 0 and 10 when `long_sel` is 1.
- R3: The raw flag reaches the sequencer through a two-flop synchronizer. A flag held high for at least W+1 consecutive sampled cycles completes the first phase. A shorter high pulse returns the block to idle with no interrupt. A drop in the very last cycle of the window also aborts.
- R4: After the first phase, the block waits in `phase` 2 while the flag stays high, with `dac_en` at 0.
- R5: After the flag falls, it must stay low for at least W+1 sampled cycles. If it rises sooner, including in the last cycle of the window, the block returns to idle with no interrupt.
- R6: `act_irq` is a single-cycle pulse. It is high in the cycle that follows the (W+3)-th rising clock edge after the flag is first sampled low.
- R7: `dac_en` is 1 in idle and during the low-level window (`phase` 3). It is 0 during high-level qualification (`phase` 1), the wait (`phase` 2) and the locked state (`phase` 4).
- R8: In the locked state (`phase` 4) the flag has no effect. A one-cycle `sw_rearm` returns the block to idle with `dac_en` at 1. `sw_rearm` has no effect in any other phase.
- R9: `phase` encodes 0 idle, 1 high-level qualify, 2 high-level held, 3 low-level qualify, 4 locked. It changes only through the transitions listed above.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cmp_flag | input | 1 | Raw high-voltage comparator flag (asynchronous) |
| long_sel | input | 1 | 0: 1-tick window, 1: 10-tick window |
| tick_div | input | 16 | Clock cycles per tick minus one |
| sw_rearm | input | 1 | Software re-arm after an interrupt |
| act_irq | output | 1 | One-cycle activation interrupt |
| dac_en | output | 1 | DAC driver enable |
| phase | output | 3 | Sequencer phase code |

## Verification
Two functions can fall in the same cycle. One is the completion of a window. The other is an abort caused by the flag changing level. The bench provokes this by holding the flag high for exactly W sampled cycles, and in a separate case low for exactly W, so that the abort lands in the last cycle of the window. In both cases it expects idle and no interrupt. It then holds W+1 cycles and expects the interrupt exactly W+3 edges after the fall. Every combination of prescale 0, 1 or 3 and both window selects is swept, with expected times computed from W.

// File: rtl/swa_pkg.sv
package swa_pkg;

  typedef enum logic [2:0] {
    PH_IDLE    = 3'd0,
    PH_HV_QUAL = 3'd1,
    PH_HV_HELD = 3'd2,
    PH_LV_QUAL = 3'd3,
    PH_LOCKED  = 3'd4
  } swa_phase_e;

  function automatic int unsigned swa_max(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/swa_sync.sv
module swa_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d_async,
  output logic q_sync
);

  logic [STAGES-1:0] chain_q;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) chain_q[0] <= 1'b0;
          else     chain_q[0] <= d_async;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) chain_q[i] <= 1'b0;
          else     chain_q[i] <= chain_q[i-1];
        end
      end
    end
  endgenerate

  assign q_sync = chain_q[STAGES-1];

endmodule

// File: rtl/swa_interval_timer.sv
module swa_interval_timer #(
  parameter int TDIV_W = 16,
  parameter int TCNT_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              restart,
  input  logic [TDIV_W-1:0] tick_div,
  input  logic [TCNT_W-1:0] target,
  output logic              done
);

  logic [TDIV_W-1:0] pre_q;
  logic [TCNT_W-1:0] ticks_q;
  logic              tick;
  logic [TCNT_W-1:0] last_tick;

  assign tick      = (pre_q == tick_div);
  assign last_tick = target - TCNT_W'(1);
  assign done      = tick && (ticks_q == last_tick);

  always_ff @(posedge clk) begin
    if (rst || restart) begin
      pre_q <= '0;
    end else if (tick) begin
      pre_q <= '0;
    end else begin
      pre_q <= pre_q + TDIV_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (rst || restart) begin
      ticks_q <= '0;
    end else if (tick && !done) begin
      ticks_q <= ticks_q + TCNT_W'(1);
    end
  end

endmodule

// File: rtl/swa_fsm.sv
module swa_fsm
  import swa_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       flag_s,
  input  logic       win_done,
  input  logic       rearm,
  output logic       restart,
  output swa_phase_e state_q,
  output logic       irq_q,
  output logic       dac_en_q
);

  swa_phase_e state_d;
  logic       irq_d;
  logic       dac_d;

  always_comb begin
    state_d = state_q;
    irq_d   = 1'b0;
    unique case (state_q)
      PH_IDLE: begin
        if (flag_s) state_d = PH_HV_QUAL;
      end
      PH_HV_QUAL: begin
        if (!flag_s)       state_d = PH_IDLE;
        else if (win_done) state_d = PH_HV_HELD;
      end
      PH_HV_HELD: begin
        if (!flag_s) state_d = PH_LV_QUAL;
      end
      PH_LV_QUAL: begin
        if (flag_s) begin
          state_d = PH_IDLE;
        end else if (win_done) begin
          state_d = PH_LOCKED;
          irq_d   = 1'b1;
        end
      end
      PH_LOCKED: begin
        if (rearm) state_d = PH_IDLE;
      end
      default: state_d = PH_IDLE;
    endcase
  end

  assign restart = (state_d != state_q);
  assign dac_d   = (state_d == PH_IDLE) || (state_d == PH_LV_QUAL);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q  <= PH_IDLE;
      irq_q    <= 1'b0;
      dac_en_q <= 1'b1;
    end else begin
      state_q  <= state_d;
      irq_q    <= irq_d;
      dac_en_q <= dac_d;
    end
  end

endmodule

// File: rtl/swire_act_seq.sv
module swire_act_seq
  import swa_pkg::*;
#(
  parameter int TDIV_W      = 16,
  parameter int SHORT_TICKS = 1,
  parameter int LONG_TICKS  = 10,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmp_flag,
  input  logic              long_sel,
  input  logic [TDIV_W-1:0] tick_div,
  input  logic              sw_rearm,
  output logic              act_irq,
  output logic              dac_en,
  output logic [2:0]        phase
);

  localparam int MAX_TICKS = swa_max(SHORT_TICKS, LONG_TICKS);
  localparam int TCNT_W    = $clog2(MAX_TICKS + 1);

  logic              flag_s;
  logic              restart;
  logic              win_done;
  logic [TCNT_W-1:0] target;
  swa_phase_e        state;

  assign target = long_sel ? TCNT_W'(LONG_TICKS) : TCNT_W'(SHORT_TICKS);

  swa_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst     (rst),
    .d_async (cmp_flag),
    .q_sync  (flag_s)
  );

  swa_interval_timer #(.TDIV_W(TDIV_W), .TCNT_W(TCNT_W)) u_timer (
    .clk      (clk),
    .rst      (rst),
    .restart  (restart),
    .tick_div (tick_div),
    .target   (target),
    .done     (win_done)
  );

  swa_fsm u_fsm (
    .clk      (clk),
    .rst      (rst),
    .flag_s   (flag_s),
    .win_done (win_done),
    .rearm    (sw_rearm),
    .restart  (restart),
    .state_q  (state),
    .irq_q    (act_irq),
    .dac_en_q (dac_en)
  );

  assign phase = state;

endmodule

// File: rtl/swire_act_seq_chk.sv
module swire_act_seq_chk
  import swa_pkg::*;
(
  input logic       clk,
  input logic       rst,
  input logic       rearm_i,
  input logic       irq_i,
  input logic       dac_en_i,
  input logic [2:0] phase_i
);

  assert_irq_single_R6: assert property (@(posedge clk) disable iff (rst)
    irq_i |=> !irq_i);

  assert_irq_from_lv_R6: assert property (@(posedge clk) disable iff (rst)
    irq_i |-> (phase_i == PH_LOCKED) && ($past(phase_i) == PH_LV_QUAL));

  assert_dac_off_hv_R7: assert property (@(posedge clk) disable iff (rst)
    ((phase_i == PH_HV_QUAL) || (phase_i == PH_HV_HELD)) |-> !dac_en_i);

  assert_dac_on_lv_R7: assert property (@(posedge clk) disable iff (rst)
    ((phase_i == PH_LV_QUAL) || (phase_i == PH_IDLE)) |-> dac_en_i);

  assert_locked_hold_R8: assert property (@(posedge clk) disable iff (rst)
    ((phase_i == PH_LOCKED) && !rearm_i) |=> (phase_i == PH_LOCKED) && !dac_en_i);

  assert_idle_exit_R9: assert property (@(posedge clk) disable iff (rst)
    (phase_i == PH_IDLE) |=> ((phase_i == PH_IDLE) || (phase_i == PH_HV_QUAL)));

  assert_held_exit_R4: assert property (@(posedge clk) disable iff (rst)
    (phase_i == PH_HV_HELD) |=> ((phase_i == PH_HV_HELD) || (phase_i == PH_LV_QUAL)));

  assert_phase_legal_R9: assert property (@(posedge clk) disable iff (rst)
    phase_i <= 3'd4);

endmodule

bind swire_act_seq swire_act_seq_chk u_chk (
  .clk      (clk),
  .rst      (rst),
  .rearm_i  (sw_rearm),
  .irq_i    (act_irq),
  .dac_en_i (dac_en),
  .phase_i  (phase)
);

// File: tb/swire_act_seq_tb.sv
`timescale 1ns/1ps
module swire_act_seq_tb;

  logic        clk = 1'b0;
  logic        rst;
  logic        cmp_flag;
  logic        long_sel;
  logic [15:0] tick_div;
  logic        sw_rearm;
  logic        act_irq;
  logic        dac_en;
  logic [2:0]  phase;

  int checks = 0;
  int errors = 0;
  int irq_seen = 0;

  always #2.5 clk = ~clk;

  swire_act_seq u_dut (
    .clk      (clk),
    .rst      (rst),
    .cmp_flag (cmp_flag),
    .long_sel (long_sel),
    .tick_div (tick_div),
    .sw_rearm (sw_rearm),
    .act_irq  (act_irq),
    .dac_en   (dac_en),
    .phase    (phase)
  );

  always @(negedge clk) if (act_irq === 1'b1) irq_seen++;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic rearm_pulse();
    sw_rearm = 1'b1;
    step();
    sw_rearm = 1'b0;
    step();
  endtask

  // Flag high for hv sampled cycles, then low; returns to idle without interrupt.
  task automatic short_hv(input int w);
    int base;
    base = irq_seen;
    cmp_flag = 1'b1;
    repeat (w) step();
    cmp_flag = 1'b0;
    repeat (w + 8) step();
    chk("R3 short high pulse phase", phase, 0);
    chk("R3 short high pulse irq", irq_seen - base, 0);
    chk("R7 idle dac after abort", dac_en, 1);
  endtask

  // Qualify high; hold for w+4 cycles; check phases along the way.
  task automatic qualify_hv(input int w);
    cmp_flag = 1'b1;
    for (int k = 1; k <= w + 4; k++) begin
      step();
      if (k == 3) begin
        chk("R9 hv qualify phase", phase, 1);
        chk("R7 dac off in hv qualify", dac_en, 0);
      end
      if (k == 4) sw_rearm = 1'b1;  // R8: ignored outside locked
      if (k == 5) sw_rearm = 1'b0;
    end
    sw_rearm = 1'b0;
    chk("R4 held phase", phase, 2);
    chk("R4 dac off while held", dac_en, 0);
  endtask

  // Full low window; optionally raise the flag right after exactly w+1 low cycles.
  task automatic low_to_irq(input int w, input bit raise_after);
    int base, first;
    base = irq_seen;
    first = -1;
    cmp_flag = 1'b0;
    for (int k = 1; k <= w + 6; k++) begin
      step();
      if (raise_after && k == w + 1) cmp_flag = 1'b1;
      if (k == 3) begin
        chk("R9 lv qualify phase", phase, 3);
        chk("R7 dac on in lv qualify", dac_en, 1);
      end
      if (act_irq === 1'b1 && first < 0) first = k;
    end
    chk("R6 irq timing", first, w + 3);
    chk("R6 irq single pulse", irq_seen - base, 1);
    chk("R8 locked phase", phase, 4);
    chk("R7 dac off when locked", dac_en, 0);
  endtask

  task automatic run_config(input int div, input bit sel);
    int w;
    int base;
    w = (sel ? 10 : 1) * (div + 1);
    tick_div = 16'(div);
    long_sel = sel;
    step();
    // R3 boundary: exactly w high cycles is one short
    short_hv(w);
    // Full sequence, flag left low afterwards
    qualify_hv(w);
    low_to_irq(w, 1'b0);
    // R8: flag ignored while locked
    base = irq_seen;
    cmp_flag = 1'b1;
    repeat (w + 10) step();
    cmp_flag = 1'b0;
    repeat (w + 10) step();
    chk("R8 locked ignores flag phase", phase, 4);
    chk("R8 locked ignores flag irq", irq_seen - base, 0);
    rearm_pulse();
    chk("R8 rearm to idle", phase, 0);
    chk("R8 rearm dac on", dac_en, 1);
    // R5 boundary: low only w cycles, then a one-cycle rise
    base = irq_seen;
    qualify_hv(w);
    cmp_flag = 1'b0;
    repeat (w) step();
    cmp_flag = 1'b1;
    step();
    cmp_flag = 1'b0;
    repeat (3 * w + 10) step();
    chk("R5 early rise phase", phase, 0);
    chk("R5 early rise irq", irq_seen - base, 0);
    // R5 boundary: exactly w+1 low then rise still interrupts
    qualify_hv(w);
    low_to_irq(w, 1'b1);
    cmp_flag = 1'b0;
    repeat (4) step();
    rearm_pulse();
    chk("R8 rearm after exact window", phase, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL R6 watchdog expired actual=1 expected=0");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst = 1'b1;
    cmp_flag = 1'b0;
    long_sel = 1'b0;
    tick_div = 16'd0;
    sw_rearm = 1'b0;
    repeat (4) step();
    chk("R1 reset phase", phase, 0);
    chk("R1 reset dac", dac_en, 1);
    chk("R1 reset irq", act_irq, 0);
    rst = 1'b0;
    step();
    chk("R1 post reset phase", phase, 0);
    chk("R1 post reset dac", dac_en, 1);
    // R2: window length W = N*(div+1) swept over prescale and select
    for (int d = 0; d < 3; d++) begin
      for (int s = 0; s < 2; s++) begin
        run_config((d == 2) ? 3 : d, s[0]);
      end
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule